// File: doc/BRIEF.md
# Synchronized Two-Channel PWM Timer

This block pairs two down-counting timer channels to make one pulse-width-modulated output. The period channel runs as a free interval timer. It reloads from its period register each time it passes zero and fires a period event when it does. Each period event restarts the duty channel in one-count mode. The duty channel drives the output high for as long as it counts. The output therefore has a period of `period+1` count ticks and a high time of `duty+1` ticks.

Both counters advance only on cycles where the shared prescaler enable `tick` is high. Software start and stop strobes control each channel. The period and duty values can be written at any time. With buffered reload enabled, a write lands in a holding register. Both holding registers are copied into the working registers together, at the moment the period channel begins a new count.

Top module: `sync_pwm_pair`

## Requirements
- R1: After reset, `pwm_out`, `irq_master` and `irq_slave` are low and `run_stat` is `2'b00`.
- R2: A software start of the period channel (`start_req[0]`, bit 0 selects the period channel and bit 1 the duty channel) raises `irq_master` for one cycle on the next cycle and sets `run_stat[0]`. `run_stat` bit 0 shows the period channel and bit 1 shows the duty channel.
- R3: While running, successive `irq_master` pulses are `(period+1)` ticks apart.
- R4: The duty channel is retriggered by every period event, and `pwm_out` rises in the cycle in which `irq_master` is high. With `duty < period`, the output stays high for `(duty+1)` ticks.
- R5: A duty value of 0 gives a high time of exactly one tick in every period.
- R6: A duty value greater than or equal to the period value keeps `pwm_out` continuously high. A retrigger in the cycle the pulse would end takes priority over the end.
- R7: Neither counter advances on a cycle where `tick` is low. With a tick every N clocks, the period and the high time both scale by N.
- R8: A stop strobe on either channel forces `pwm_out` low on the next cycle and clears the selected bits of `run_stat`. After both channels are stopped, no further `irq_master` pulse occurs.
- R9: With `reload_en` high, writes to the period and duty registers do not change the period in progress. Both new values take effect together from the next period event onward.
- R10: `irq_slave` pulses for one cycle in the cycle `pwm_out` falls at the end of a duty count, once per period when `duty < period`, and never when `duty >= period`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled count enable shared by both channels |
| start_req | input | 2 | Start strobes, bit 0 period channel, bit 1 duty channel |
| stop_req | input | 2 | Stop strobes, same bit order; stop wins over start |
| reload_en | input | 1 | 1 = buffered reload at period start, 0 = direct write |
| wr_period | input | 1 | Write strobe for the period register |
| period_data | input | CNT_W | Period value (period is value+1 ticks) |
| wr_duty | input | 1 | Write strobe for the duty register |
| duty_data | input | CNT_W | Duty value (high time is value+1 ticks) |
| pwm_out | output | 1 | PWM output |
| irq_master | output | 1 | One-cycle pulse at every period channel count start |
| irq_slave | output | 1 | One-cycle pulse at the end of each duty count |
| run_stat | output | 2 | Channel enable status, same bit order as the strobes |

## Verification
The bench drives the main function with a set of period and duty pairs. A middle duty against a long period separates the high-time count from the period count. A duty of zero exposes off-by-one errors in the one-count end. A duty equal to the period and a duty above it show whether a retrigger beats the pulse end. Tick spacings of one, two and three clocks show whether any counter steps on a cycle without an enable. A mid-run rewrite with buffering enabled shows whether the period in progress is protected and whether both values switch over in the same period.

// File: rtl/sync_pwm_pair_pkg.sv
// Package: shared constants for the synchronized PWM timer pair.
// Assumes channel bit 0 is the period (master) channel and bit 1 the duty (slave) channel.
package sync_pwm_pair_pkg;
    localparam int NUM_CH    = 2;
    localparam int CH_PERIOD = 0;
    localparam int CH_DUTY   = 1;
endpackage

// File: rtl/pwm_data_regs.sv
// Module: period/duty data registers with optional buffered reload.
// Holding registers always capture writes. In direct mode the working
// registers are written at once. In buffered mode both working registers
// copy the holding registers together on a commit (period channel count start).
// The values to load on a commit are presented combinationally.
module pwm_data_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_en,
    input  logic             commit,
    input  logic             wr_period,
    input  logic [CNT_W-1:0] period_data,
    input  logic             wr_duty,
    input  logic [CNT_W-1:0] duty_data,
    output logic [CNT_W-1:0] period_load,
    output logic [CNT_W-1:0] duty_load
);
    logic [CNT_W-1:0] per_hold, duty_hold;
    logic [CNT_W-1:0] per_work, duty_work;

    // Holding registers: capture every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_hold  <= '0;
            duty_hold <= '0;
        end else begin
            if (wr_period) per_hold  <= period_data;
            if (wr_duty)   duty_hold <= duty_data;
        end
    end

    // Working registers: direct write, or a joint copy on commit when buffered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_work  <= '0;
            duty_work <= '0;
        end else if (reload_en) begin
            if (commit) begin
                per_work  <= per_hold;
                duty_work <= duty_hold;
            end
        end else begin
            if (wr_period) per_work  <= period_data;
            if (wr_duty)   duty_work <= duty_data;
        end
    end

    // Load values: a buffered commit uses the holding copies this cycle.
    always_comb begin
        period_load = reload_en ? per_hold  : per_work;
        duty_load   = reload_en ? duty_hold : duty_work;
    end
endmodule

// File: rtl/pwm_period_ch.sv
// Module: period (master) channel, an interval down-counter.
// A software start loads the counter and fires a period event at once.
// While running, a tick at count zero reloads the counter and fires an event.
// Stop beats start. Assumes load_val is valid in the cycle the event fires.
module pwm_period_ch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic [CNT_W-1:0] load_val,
    output logic             evt,
    output logic             running,
    output logic             irq
);
    logic [CNT_W-1:0] cnt;

    // Period event: software start or a counted pass through zero.
    always_comb begin
        evt = !stop && (start || (running && tick && (cnt == '0)));
    end

    // Counter and run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (stop) begin
            running <= 1'b0;
        end else if (evt) begin
            cnt     <= load_val;
            running <= 1'b1;
        end else if (running && tick) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Interrupt: registered copy of the period event.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= evt;
    end
endmodule

// File: rtl/pwm_duty_ch.sv
// Module: duty (slave) channel, a one-count down-counter that drives the output.
// It is armed by its start bit and cleared by its stop bit. An armed channel
// restarts on every trigger, even mid-count. A restart beats the end of count.
// Any stop (kill) drops the output at once.
module pwm_duty_ch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             arm_set,
    input  logic             arm_clr,
    input  logic             kill,
    input  logic             trig,
    input  logic [CNT_W-1:0] load_val,
    output logic             armed,
    output logic             busy,
    output logic             irq
);
    logic [CNT_W-1:0] cnt;
    logic             trig_ok;

    // Trigger accepted when armed now or armed in the same cycle.
    always_comb begin
        trig_ok = trig && (armed || arm_set) && !arm_clr && !kill;
    end

    // Arm flag: stop wins over start.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (arm_clr) armed <= 1'b0;
        else if (arm_set) armed <= 1'b1;
    end

    // One-count sequence: load, count ticks, end with an interrupt at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (kill) begin
                busy <= 1'b0;
            end else if (trig_ok) begin
                cnt  <= load_val;
                busy <= 1'b1;
            end else if (busy && tick) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    irq  <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sync_pwm_pair.sv
// Module: top of the synchronized PWM timer pair.
// The period channel's event loads both counters and, in buffered mode,
// commits both data registers. The duty channel's busy state is the PWM pin.
// Assumes tick is a one-clock-wide enable from a shared prescaler.
module sync_pwm_pair
    import sync_pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NUM_CH-1:0] start_req,
    input  logic [NUM_CH-1:0] stop_req,
    input  logic              reload_en,
    input  logic              wr_period,
    input  logic [CNT_W-1:0]  period_data,
    input  logic              wr_duty,
    input  logic [CNT_W-1:0]  duty_data,
    output logic              pwm_out,
    output logic              irq_master,
    output logic              irq_slave,
    output logic [NUM_CH-1:0] run_stat
);
    logic             per_evt;
    logic             per_run;
    logic             duty_armed;
    logic             duty_busy;
    logic             any_stop;
    logic [CNT_W-1:0] period_load;
    logic [CNT_W-1:0] duty_load;

    // Any stop strobe holds the output low.
    always_comb any_stop = |stop_req;

    pwm_data_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload_en   (reload_en),
        .commit      (per_evt),
        .wr_period   (wr_period),
        .period_data (period_data),
        .wr_duty     (wr_duty),
        .duty_data   (duty_data),
        .period_load (period_load),
        .duty_load   (duty_load)
    );

    pwm_period_ch #(.CNT_W(CNT_W)) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (start_req[CH_PERIOD]),
        .stop     (stop_req[CH_PERIOD]),
        .load_val (period_load),
        .evt      (per_evt),
        .running  (per_run),
        .irq      (irq_master)
    );

    pwm_duty_ch #(.CNT_W(CNT_W)) u_duty (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .arm_set  (start_req[CH_DUTY]),
        .arm_clr  (stop_req[CH_DUTY]),
        .kill     (any_stop),
        .trig     (per_evt),
        .load_val (duty_load),
        .armed    (duty_armed),
        .busy     (duty_busy),
        .irq      (irq_slave)
    );

    // Output and status wiring.
    always_comb begin
        pwm_out            = duty_busy;
        run_stat[CH_PERIOD] = per_run;
        run_stat[CH_DUTY]   = duty_armed;
    end
endmodule

// File: rtl/sync_pwm_pair_chk.sv
// Checker: temporal properties of the synchronized PWM pair, bound to the top.
module sync_pwm_pair_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [1:0]       start_req,
    input logic [1:0]       stop_req,
    input logic             reload_en,
    input logic             wr_period,
    input logic [CNT_W-1:0] period_data,
    input logic             wr_duty,
    input logic [CNT_W-1:0] duty_data,
    input logic             pwm_out,
    input logic             irq_master,
    input logic             irq_slave,
    input logic [1:0]       run_stat
);
    p_start_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req[0] && !stop_req[0]) |=> (irq_master && run_stat[0]));

    p_rise_with_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> irq_master);

    p_no_event_without_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start_req[0]) |=> !irq_master);

    p_stop_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|stop_req) |=> (!pwm_out && !irq_slave));

    p_stop_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req[0] |=> !run_stat[0]);

    p_slave_irq_at_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_slave |-> (!pwm_out && $past(pwm_out)));
endmodule

bind sync_pwm_pair sync_pwm_pair_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_sync_pwm_pair.sv
`timescale 1ns/1ps
module test_sync_pwm_pair;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic [1:0]   start_req = '0;
    logic [1:0]   stop_req = '0;
    logic         reload_en = 1'b0;
    logic         wr_period = 1'b0;
    logic [W-1:0] period_data = '0;
    logic         wr_duty = 1'b0;
    logic [W-1:0] duty_data = '0;
    logic         pwm_out, irq_master, irq_slave;
    logic [1:0]   run_stat;

    int n_run = 0;
    int n_fail = 0;
    int div_cur = 1;
    bit done = 1'b0;

    // Vectors: {period, duty, tick spacing}
    localparam logic [47:0] VEC [7] = '{
        {16'd9,  16'd3,  16'd1},   // R3 R4 mid duty
        {16'd9,  16'd0,  16'd1},   // R5 zero duty
        {16'd9,  16'd9,  16'd1},   // R6 duty equals period
        {16'd5,  16'd12, 16'd1},   // R6 duty above period
        {16'd7,  16'd2,  16'd2},   // R7 tick every 2
        {16'd15, 16'd7,  16'd3},   // R7 tick every 3
        {16'd4,  16'd3,  16'd1}    // R4 near full
    };

    sync_pwm_pair #(.CNT_W(W)) i_sync_pwm_pair (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_req),
        .stop_req(stop_req), .reload_en(reload_en), .wr_period(wr_period),
        .period_data(period_data), .wr_duty(wr_duty), .duty_data(duty_data),
        .pwm_out(pwm_out), .irq_master(irq_master), .irq_slave(irq_slave),
        .run_stat(run_stat)
    );

    always #2.5 clk = ~clk;

    // Tick generator: one high cycle every div_cur clocks.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            tick = (ph == 0);
            ph = (ph + 1 >= div_cur) ? 0 : ph + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_irq();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!irq_master && guard < 2000);
    endtask

    // Entered at a negedge where irq_master is high; returns at the next such negedge.
    task automatic count_window(output int per, output int hi, output int sirq);
        per = 0; hi = 0; sirq = 0;
        do begin
            per++;
            if (pwm_out) hi++;
            if (irq_slave) sirq++;
            @(negedge clk);
            wr_period = 1'b0;
            wr_duty = 1'b0;
        end while (!irq_master && per < 2000);
    endtask

    task automatic pulse_stop();
        stop_req = 2'b11;
        @(negedge clk);
        stop_req = 2'b00;
    endtask

    task automatic program_and_start(input int p, input int d);
        period_data = W'(p); duty_data = W'(d);
        wr_period = 1'b1; wr_duty = 1'b1;
        @(negedge clk);
        wr_period = 1'b0; wr_duty = 1'b0;
        start_req = 2'b11;
        @(negedge clk);
        start_req = 2'b00;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int per, hi, sirq;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pwm", int'(pwm_out), 0);
        check("R1 irqs", int'(irq_master) + int'(irq_slave), 0);
        check("R1 run_stat", int'(run_stat), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 software start
        program_and_start(9, 3);
        check("R2 irq_master after start", int'(irq_master), 1);
        check("R2 run_stat", int'(run_stat), 3);
        check("R4 pwm rises with irq", int'(pwm_out), 1);
        @(negedge clk);
        check("R2 irq one cycle", int'(irq_master), 0);
        pulse_stop();

        // Table walk: R3 R4 R5 R6 R7 R10
        for (int i = 0; i < 7; i++) begin
            int p, d, dv, exp_per, exp_hi, exp_si;
            p  = int'(VEC[i][47:32]);
            d  = int'(VEC[i][31:16]);
            dv = int'(VEC[i][15:0]);
            exp_per = (p + 1) * dv;
            exp_hi  = (d >= p) ? exp_per : (d + 1) * dv;
            exp_si  = (d >= p) ? 0 : 1;
            pulse_stop();
            div_cur = dv;
            reload_en = 1'b0;
            repeat (4) @(negedge clk);
            program_and_start(p, d);
            count_window(per, hi, sirq);
            count_window(per, hi, sirq);
            check("R3 R7 period", per, exp_per);
            check("R4 R5 R6 R7 high time", hi, exp_hi);
            check("R10 slave irq count", sirq, exp_si);
        end

        // R9 buffered reload
        pulse_stop();
        div_cur = 1;
        reload_en = 1'b1;
        repeat (2) @(negedge clk);
        program_and_start(9, 3);
        count_window(per, hi, sirq);
        period_data = 16'd19; duty_data = 16'd9;
        wr_period = 1'b1; wr_duty = 1'b1;
        count_window(per, hi, sirq);
        check("R9 old period kept", per, 10);
        check("R9 old duty kept", hi, 4);
        count_window(per, hi, sirq);
        check("R9 new period", per, 20);
        check("R9 new duty", hi, 10);

        // R8 stop
        wait_irq();
        repeat (2) @(negedge clk);
        stop_req = 2'b11;
        @(negedge clk);
        stop_req = 2'b00;
        check("R8 pwm low", int'(pwm_out), 0);
        check("R8 run_stat", int'(run_stat), 0);
        begin
            int seen = 0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (irq_master || pwm_out) seen++;
            end
            check("R8 no activity after stop", seen, 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule